// File: doc/BRIEF.md
# Sequential Read Prefetcher for a Double-Width Flash Array

This block connects a 32-bit processor read port to a flash array that returns 64 bits per access. In normal operation every processor read starts its own array access and completes after a programmable number of wait states. In pipelined operation the array is read one 64-bit word at a time. The two 32-bit halves are handed out separately, and the following 64-bit word is fetched ahead of need. A processor that walks through addresses in order then sees no wait states after its first access.

The effective mode is the pipeline enable masked by a configuration override: an asserted override forces normal operation. The effective mode is normal out of reset. Whenever the effective mode flips, everything held in the buffers is discarded. Any read that does not continue the buffered stream drops the buffers and restarts with an initial access.

The processor holds `cpuReq` and `cpuAddr` until `cpuReady` is seen high at a rising edge. `cpuAddr` is a 32-bit-word address. Its bit 0 picks the half of the 64-bit word: 0 selects bits 31:0 and 1 selects bits 63:32. The upper bits form the 64-bit word index driven on `arrAddr`. The array is modelled as an asynchronous read that is held for the whole access.

Top module: `flash_read_prefetch`

## Requirements
- R1: While reset is held and right after it, `cpuReady` and `arrRd` are low and the block runs in normal mode, so the first read takes the normal wait-state count.
- R2: In normal mode every read raises `arrRd` and completes exactly `cfgNormWait`+1 cycles after the request is first presented. It returns the half of the 64-bit word selected by address bit 0 (0 selects bits 31:0).
- R3: Normal mode keeps no data: repeating an address, or reading the other half of the same 64-bit word, costs the full normal wait count again.
- R4: In pipeline mode a read that misses every buffer completes after 1 wait state when `cfgPipeWait` is 0, and after 2 when it is 1.
- R5: In pipeline mode, once a 64-bit word has been delivered, reads of either of its halves complete with zero wait states (`cpuReady` in the cycle the request is presented).
- R6: In pipeline mode a stream of back-to-back reads at consecutive addresses completes every read after the first with zero wait states, for both `cfgPipeWait` settings. Idle gaps inside the stream do not break this.
- R7: In pipeline mode, in the cycle after an array access completes a read, `arrRd` is high with `arrAddr` equal to that word index plus one (the prefetch).
- R8: A pipeline read outside the current word and outside the prefetched word discards both buffers. A later return to the earlier word pays the initial wait count again.
- R9: With `cfgOverride` high the block uses normal-mode timing even when `cfgPipeEn` is high.
- R10: In the cycle where the effective mode changes, no read completes and all buffered data and any array access in progress are dropped. A read presented in that cycle completes one cycle plus the new mode's initial wait count later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPipeEn | input | 1 | Pipeline mode request |
| cfgOverride | input | 1 | Forces normal mode when high |
| cfgPipeWait | input | 1 | Pipeline initial wait: 0 gives 1 state, 1 gives 2 |
| cfgNormWait | input | NWAIT_W | Normal wait states minus one |
| cpuReq | input | 1 | Read request, held until ready |
| cpuAddr | input | ADDR_W | 32-bit word address |
| cpuReady | output | 1 | Read completes this cycle |
| cpuData | output | HALF_W | Read data, valid with cpuReady |
| arrRd | output | 1 | Array access in progress |
| arrAddr | output | ADDR_W-1 | 64-bit word index being read |
| arrData | input | 2*HALF_W | Array read data |

## Verification
Two events can land on the same edge: the prefetch of the next word finishing, and the processor taking the second half of the current word. With a one-wait initial access the prefetch ends exactly as that half is read, so the fetched word must go to the spare buffer while the current buffer serves the read. With a two-wait access it ends exactly as the processor asks for that new word, so the array data must be forwarded directly. Back-to-back consecutive streams under both wait settings provoke this case, and every read is judged on zero latency and on data computed from its address. A configuration flip issued in the same cycle as a read request provokes the second collision, which is judged by the one-cycle penalty plus a full initial access.

// File: rtl/fpf_pkg.sv
package fpf_pkg;

  typedef enum logic [1:0] {
    SRC_CUR = 2'd0,
    SRC_NXT = 2'd1,
    SRC_ARR = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    loadCurArr;
    logic    loadCurNxt;
    logic    loadNxtArr;
    srcSel_e sel;
    logic    half;
  } dpStrobe_t;

endpackage

// File: rtl/fpf_ctrl.sv
module fpf_ctrl
  import fpf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NWAIT_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgPipeEn,
  input  logic                cfgOverride,
  input  logic                cfgPipeWait,
  input  logic [NWAIT_W-1:0]  cfgNormWait,
  input  logic                cpuReq,
  input  logic [ADDR_W-1:0]   cpuAddr,
  output logic                cpuReady,
  output logic                arrRd,
  output logic [ADDR_W-2:0]   arrAddr,
  output dpStrobe_t           strobe
);
  localparam int LINE_W = ADDR_W - 1;

  logic               pipeOnQ;
  logic               curValid, nxtValid, engActive;
  logic [LINE_W-1:0]  curLine, nxtLine, engLine;
  logic [NWAIT_W-1:0] engCnt;

  logic               pipeOn, modeChg, accept;
  logic [LINE_W-1:0]  reqLine;
  logic               reqHalf;
  logic               engDone, hitCur, hitNxt, hitEng, pending, miss;
  logic [NWAIT_W-1:0] startCnt;

  always_comb begin
    pipeOn   = cfgPipeEn & ~cfgOverride;
    modeChg  = pipeOn != pipeOnQ;
    accept   = cpuReq & ~modeChg;
    reqLine  = cpuAddr[ADDR_W-1:1];
    reqHalf  = cpuAddr[0];
    engDone  = engActive && (engCnt == '0);
    hitCur   = pipeOnQ && curValid && (reqLine == curLine);
    hitNxt   = pipeOnQ && nxtValid && (reqLine == nxtLine);
    hitEng   = engDone && (reqLine == engLine);
    pending  = engActive && (engCnt != '0) && (reqLine == engLine);
    miss     = accept && !(hitCur || hitNxt || hitEng || pending);
    startCnt = pipeOnQ ? NWAIT_W'(cfgPipeWait) : cfgNormWait;
  end

  assign cpuReady = accept && (hitCur || hitNxt || hitEng);
  assign arrRd    = engActive;
  assign arrAddr  = engLine;

  always_comb begin
    strobe.loadCurArr = accept && hitEng && pipeOnQ;
    strobe.loadCurNxt = accept && hitNxt;
    strobe.loadNxtArr = engDone && pipeOnQ && !modeChg && !(accept && hitEng);
    strobe.half       = reqHalf;
    if (hitEng)      strobe.sel = SRC_ARR;
    else if (hitNxt) strobe.sel = SRC_NXT;
    else             strobe.sel = SRC_CUR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeOnQ   <= 1'b0;
      curValid  <= 1'b0;
      nxtValid  <= 1'b0;
      engActive <= 1'b0;
      curLine   <= '0;
      nxtLine   <= '0;
      engLine   <= '0;
      engCnt    <= '0;
    end else if (modeChg) begin
      pipeOnQ   <= pipeOn;
      curValid  <= 1'b0;
      nxtValid  <= 1'b0;
      engActive <= 1'b0;
    end else begin
      if (engActive && engCnt != '0) engCnt <= engCnt - 1'b1;
      if (engDone) begin
        if (accept && hitEng) begin
          if (pipeOnQ) begin
            curValid <= 1'b1;
            curLine  <= engLine;
            engLine  <= engLine + LINE_W'(1);
            engCnt   <= startCnt;
          end else begin
            engActive <= 1'b0;
          end
        end else begin
          engActive <= 1'b0;
          if (pipeOnQ) begin
            nxtValid <= 1'b1;
            nxtLine  <= engLine;
          end
        end
      end
      if (accept && hitNxt) begin
        curValid  <= 1'b1;
        curLine   <= nxtLine;
        nxtValid  <= 1'b0;
        engActive <= 1'b1;
        engLine   <= nxtLine + LINE_W'(1);
        engCnt    <= startCnt;
      end
      if (miss) begin
        curValid  <= 1'b0;
        nxtValid  <= 1'b0;
        engActive <= 1'b1;
        engLine   <= reqLine;
        engCnt    <= startCnt;
      end
    end
  end

  // R2
  normal_ready_arr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !pipeOnQ) |-> arrRd);

  // R3
  normal_nobuf_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pipeOnQ |-> (!curValid && !nxtValid));

  // R10
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> !arrRd);

  // R6
  ready_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);

  // R7
  prefetch_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && pipeOnQ && arrRd && engCnt == '0 && cpuAddr[ADDR_W-1:1] == arrAddr)
      |=> (arrRd && arrAddr == $past(arrAddr) + LINE_W'(1)));

endmodule

// File: rtl/fpf_datapath.sv
module fpf_datapath
  import fpf_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [2*HALF_W-1:0] arrData,
  output logic [HALF_W-1:0]   cpuData
);
  localparam int WORD_W = 2 * HALF_W;

  logic [WORD_W-1:0] curData, nxtData, srcWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curData <= '0;
      nxtData <= '0;
    end else begin
      if (strobe.loadCurArr)      curData <= arrData;
      else if (strobe.loadCurNxt) curData <= nxtData;
      if (strobe.loadNxtArr)      nxtData <= arrData;
    end
  end

  always_comb begin
    case (strobe.sel)
      SRC_ARR: srcWord = arrData;
      SRC_NXT: srcWord = nxtData;
      default: srcWord = curData;
    endcase
    cpuData = strobe.half ? srcWord[WORD_W-1:HALF_W] : srcWord[HALF_W-1:0];
  end

  // R6
  cur_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCurArr, strobe.loadCurNxt}));

endmodule

// File: rtl/flash_read_prefetch.sv
module flash_read_prefetch
  import fpf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NWAIT_W = 3,
  parameter int HALF_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgPipeEn,
  input  logic                cfgOverride,
  input  logic                cfgPipeWait,
  input  logic [NWAIT_W-1:0]  cfgNormWait,
  input  logic                cpuReq,
  input  logic [ADDR_W-1:0]   cpuAddr,
  output logic                cpuReady,
  output logic [HALF_W-1:0]   cpuData,
  output logic                arrRd,
  output logic [ADDR_W-2:0]   arrAddr,
  input  logic [2*HALF_W-1:0] arrData
);
  dpStrobe_t strobe;

  fpf_ctrl #(.ADDR_W(ADDR_W), .NWAIT_W(NWAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgPipeEn(cfgPipeEn), .cfgOverride(cfgOverride),
    .cfgPipeWait(cfgPipeWait), .cfgNormWait(cfgNormWait),
    .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuReady(cpuReady),
    .arrRd(arrRd), .arrAddr(arrAddr), .strobe(strobe)
  );

  fpf_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .arrData(arrData), .cpuData(cpuData)
  );

endmodule

// File: tb/flash_read_prefetch_tb.sv
`timescale 1ns/1ps
module flash_read_prefetch_tb;
  localparam int ADDR_W = 16;
  localparam int NWAIT_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPipeEn = 1'b0, cfgOverride = 1'b0, cfgPipeWait = 1'b0;
  logic [NWAIT_W-1:0] cfgNormWait = 3'd2;
  logic cpuReq = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic cpuReady, arrRd;
  logic [31:0] cpuData;
  logic [ADDR_W-2:0] arrAddr;
  logic [63:0] arrData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] expWord(input logic [ADDR_W-1:0] a);
    return ({16'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic int expLat(input bit pipe, input bit pw, input int nw);
    return pipe ? (pw ? 2 : 1) : nw + 1;
  endfunction

  assign arrData = {expWord({arrAddr, 1'b1}), expWord({arrAddr, 1'b0})};

  flash_read_prefetch #(.ADDR_W(ADDR_W), .NWAIT_W(NWAIT_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgPipeEn(cfgPipeEn), .cfgOverride(cfgOverride),
    .cfgPipeWait(cfgPipeWait), .cfgNormWait(cfgNormWait),
    .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuReady(cpuReady), .cpuData(cpuData),
    .arrRd(arrRd), .arrAddr(arrAddr), .arrData(arrData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cpuReq = 1'b0;
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input bit togOv,
                    output int lat, output logic [31:0] d);
    @(negedge clk);
    cpuReq = 1'b1;
    cpuAddr = a;
    if (togOv) cfgOverride = ~cfgOverride;
    lat = 0;
    #1;
    while (!cpuReady && lat < 40) begin
      @(negedge clk);
      lat++;
      #1;
    end
    d = cpuData;
    if (!cpuReady) begin
      checks++;
      errors++;
      $display("FAIL read timeout at %0h actual 0 expected 1", a);
    end
  endtask

  task automatic rdChk(input logic [ADDR_W-1:0] a, input bit togOv,
                       input int eLat, input string tag);
    int lat;
    logic [31:0] d;
    rd(a, togOv, lat, d);
    check(lat == eLat, {tag, " latency"}, lat, eLat);
    check(d == expWord(a), {tag, " data"}, d, expWord(a));
  endtask

  task automatic setCfg(input bit pe, input bit ov, input bit pw, input int nw);
    @(negedge clk);
    cpuReq = 1'b0;
    cfgPipeEn = pe;
    cfgOverride = ov;
    cfgPipeWait = pw;
    cfgNormWait = NWAIT_W'(nw);
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(cpuReady == 1'b0, "R1 ready in reset", cpuReady, 0);
    check(arrRd == 1'b0, "R1 arrRd in reset", arrRd, 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(arrRd == 1'b0, "R1 arrRd after reset", arrRd, 0);

    // R1 R2: normal mode first access, 3 waits
    rdChk(16'h0010, 0, 3, "R1 first read");
    // R3: repeat and other half cost full time
    rdChk(16'h0010, 0, 3, "R3 repeat");
    rdChk(16'h0011, 0, 3, "R3 other half");

    // R9: override beats enable
    setCfg(1, 1, 0, 2);
    rdChk(16'h0020, 0, 3, "R9 override");
    rdChk(16'h0021, 0, 3, "R9 override seq");

    // R4: one-wait initial access
    setCfg(1, 0, 0, 2);
    rdChk(16'h0040, 0, 1, "R4 initial w1");
    // R7: prefetch of word 0x21 in the next cycle
    @(negedge clk);
    cpuReq = 1'b0;
    #1;
    check(arrRd == 1'b1, "R7 prefetch rd", arrRd, 1);
    check(arrAddr == 15'h21, "R7 prefetch addr", arrAddr, 15'h21);
    // R5: both halves of the current word
    rdChk(16'h0041, 0, 0, "R5 high half");
    rdChk(16'h0040, 0, 0, "R5 low half");
    // R6: stream with w1
    for (int i = 2; i < 10; i++) rdChk(16'h0040 + 16'(i), 0, 0, "R6 stream w1");
    idle(3);
    rdChk(16'h004A, 0, 0, "R6 after gap");

    // R4 R6: two-wait initial, then back-to-back stream
    setCfg(1, 0, 1, 2);
    rdChk(16'h0100, 0, 2, "R4 initial w2");
    for (int i = 1; i < 9; i++) rdChk(16'h0100 + 16'(i), 0, 0, "R6 stream w2");

    // R8: jump away and back
    rdChk(16'h0200, 0, 2, "R8 jump");
    rdChk(16'h0108, 0, 2, "R8 return");
    rdChk(16'h0109, 0, 0, "R8 resumed");

    // R10: mode flips in the cycle a read is presented
    rdChk(16'h0109, 1, 4, "R10 to normal");
    rdChk(16'h0109, 1, 3, "R10 to pipeline");

    // Random phase
    void'($urandom(32'd2024));
    for (int blk = 0; blk < 15; blk++) begin
      bit pe, ov, pw, pipe;
      int nw;
      logic [ADDR_W-1:0] a, prev;
      bit havePrev;
      pe = 1'($urandom % 4 != 0);
      ov = 1'($urandom % 4 == 0);
      pw = 1'($urandom % 2);
      nw = int'($urandom % 4);
      pipe = pe && !ov;
      setCfg(pe, ov, pw, nw);
      havePrev = 0;
      prev = '0;
      for (int k = 0; k < 20; k++) begin
        int sel, lat, gap;
        logic [31:0] d;
        sel = int'($urandom % 10);
        if (!havePrev || sel < 2) a = ADDR_W'($urandom);
        else if (sel < 4) a = prev ^ 16'h0001;
        else a = prev + 16'h0001;
        gap = int'($urandom % 3);
        if (gap > 0) idle(gap);
        rd(a, 0, lat, d);
        check(d == expWord(a), "R2 R6 random data", d, expWord(a));
        if (!pipe)
          check(lat == expLat(0, pw, nw), "R2 R9 random normal latency", lat, expLat(0, pw, nw));
        else if (havePrev && (a[ADDR_W-1:1] == prev[ADDR_W-1:1]))
          check(lat == 0, "R5 random same word", lat, 0);
        else
          check(lat <= expLat(1, pw, nw), "R4 random pipe latency", lat, expLat(1, pw, nw));
        prev = a;
        havePrev = 1;
      end
    end

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule